// File: doc/BRIEF.md
# Switch-Bank Output Selector with Host Override

This block drives a five-bit selectable output group and a single stand-alone output bit. Two six-bit stored configuration words supply the defaults: bits 4..0 of a word feed the five-bit group and bit 5 feeds the stand-alone bit. Two select pins choose between the stored words and a five-bit bank of external switch inputs. When the switch bank drives the group, the stand-alone bit does not follow it. It keeps the last stored-word value it saw. It acts as a latch that is transparent while stored data is selected.

A host control word can take over both select lines. It holds an enable bit and two select values. While it is disabled the select pins decide. The host can also read back the resolved switch levels. Any select pin or switch input whose drive flag is low reads as logic 1, which models a pull-up. If stored word 1 is kept at zero, select1 works as an all-zero force, and select0 chooses between the switches and stored data. A design built for a single stored word can use the block this way.

Top module: `swbank_out_sel`

## Requirements
- R1: While `rst` is high at a rising edge, `grp_out`, `solo_out` and `sw_rd` become all zero after that edge, and the host control word becomes disabled.
- R2: With effective select1=1 and select0=0, one edge later `grp_out` equals bits 4..0 of `cfg0` and `solo_out` equals bit 5 of `cfg0`.
- R3: With effective select1=0 and select0=0, one edge later `grp_out` equals bits 4..0 of `cfg1` and `solo_out` equals bit 5 of `cfg1`.
- R4: With effective select0=1, one edge later `grp_out` equals the resolved switch inputs, whatever select1 is.
- R5: While effective select0=1, `solo_out` does not change, even when `cfg0`, `cfg1` or select1 change.
- R6: The value that `solo_out` holds under select0=1 is the one it loaded at the last edge where select0 was 0. That value came from `cfg0` bit 5 if select1 was 1 at that edge, and from `cfg1` bit 5 otherwise.
- R7: A pulse on `ovr_wr` stores `ovr_wdata` (bit 2 enable, bit 1 select1, bit 0 select0). From the following edge on, while enable is 1, the stored select bits replace the pins and the pin levels have no effect.
- R8: After a host write with enable 0, or after reset, the select pins decide again.
- R9: A select pin or switch input whose drive flag (`sel_drv`, `sw_drv`) is 0 reads as 1.
- R10: `sw_rd` equals the resolved switch inputs one edge after they are applied.
- R11: With `cfg1` all zero and select1=0, `grp_out` is zero when select0=0 and follows the switches when select0=1, and `solo_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 2 | Select pins, bit 1 = select1, bit 0 = select0 |
| sel_drv | input | 2 | Drive flags for the select pins (0 = undriven, reads 1) |
| sw_in | input | 5 | External switch levels |
| sw_drv | input | 5 | Drive flags for the switch inputs |
| cfg0 | input | 6 | Stored configuration word 0 |
| cfg1 | input | 6 | Stored configuration word 1 |
| ovr_wr | input | 1 | Host write strobe for the control word |
| ovr_wdata | input | 3 | Host control word: enable, select1, select0 |
| grp_out | output | 5 | Selectable five-bit output group |
| solo_out | output | 1 | Stand-alone latched output bit |
| sw_rd | output | 5 | Host readback of the resolved switch levels |

## Verification
A stuck or stale latch register is visible on `solo_out` only at the first edge after select0 falls. Until then a wrong held value and a correct one look the same. For that reason the stimulus alternates between stored words that carry different bit-5 values before every capture. A host control word that is not cleared shows up one edge after reset, when the outputs follow the old override instead of the pins. Wrong select decoding or pull-up resolution shows on `grp_out` at the first edge after the inputs change.

// File: rtl/swbank_pkg.sv
package swbank_pkg;
  // Host control word: enable plus two select values
  typedef struct packed {
    logic en;
    logic sel1;
    logic sel0;
  } hctl_t;

  localparam int SEL_W = 2;
  localparam hctl_t HCTL_RESET = '{en: 1'b0, sel1: 1'b0, sel0: 1'b0};
endpackage

// File: rtl/swbank_pullup.sv
module swbank_pullup #(
  parameter int W = 5
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] drv,
  output logic [W-1:0] val
);
  // An undriven line reads as logic 1
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign val[i] = drv[i] ? raw[i] : 1'b1;
  end
endmodule

// File: rtl/swbank_selctl.sv
module swbank_selctl
  import swbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  hctl_t            wdata,
  input  logic [SEL_W-1:0] pin_sel,
  output hctl_t            hctl_q,
  output logic [SEL_W-1:0] eff_sel
);
  always_ff @(posedge clk) begin
    if (rst)     hctl_q <= HCTL_RESET;
    else if (wr) hctl_q <= wdata;
  end

  always_comb begin
    if (hctl_q.en) eff_sel = {hctl_q.sel1, hctl_q.sel0};
    else           eff_sel = pin_sel;
  end
endmodule

// File: rtl/swbank_outstage.sv
module swbank_outstage #(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       eff_sel,
  input  logic [GRP_W-1:0] sw_val,
  input  logic [GRP_W:0]   cfg0,
  input  logic [GRP_W:0]   cfg1,
  output logic [GRP_W-1:0] grp_q,
  output logic             solo_q,
  output logic [GRP_W-1:0] sw_rd_q
);
  localparam int SOLO_BIT = GRP_W;

  logic [GRP_W:0] stored_pick;
  logic           pick_sw;

  // select1 high picks word 0, low picks word 1
  assign stored_pick = eff_sel[1] ? cfg0 : cfg1;
  assign pick_sw     = eff_sel[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q   <= '0;
      solo_q  <= 1'b0;
      sw_rd_q <= '0;
    end else begin
      sw_rd_q <= sw_val;
      grp_q   <= pick_sw ? sw_val : stored_pick[GRP_W-1:0];
      // transparent while stored data selected, holds otherwise
      if (!pick_sw) solo_q <= stored_pick[SOLO_BIT];
    end
  end
endmodule

// File: rtl/swbank_out_sel.sv
module swbank_out_sel #(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_pin,
  input  logic [1:0]       sel_drv,
  input  logic [GRP_W-1:0] sw_in,
  input  logic [GRP_W-1:0] sw_drv,
  input  logic [GRP_W:0]   cfg0,
  input  logic [GRP_W:0]   cfg1,
  input  logic             ovr_wr,
  input  logic [2:0]       ovr_wdata,
  output logic [GRP_W-1:0] grp_out,
  output logic             solo_out,
  output logic [GRP_W-1:0] sw_rd
);
  import swbank_pkg::*;

  logic [1:0]       sel_res;
  logic [GRP_W-1:0] sw_res;
  logic [1:0]       eff_sel;
  hctl_t            hctl_q;

  swbank_pullup #(.W(2)) u_selpu (
    .raw(sel_pin), .drv(sel_drv), .val(sel_res)
  );

  swbank_pullup #(.W(GRP_W)) u_swpu (
    .raw(sw_in), .drv(sw_drv), .val(sw_res)
  );

  swbank_selctl u_ctl (
    .clk(clk), .rst(rst), .wr(ovr_wr), .wdata(hctl_t'(ovr_wdata)),
    .pin_sel(sel_res), .hctl_q(hctl_q), .eff_sel(eff_sel)
  );

  swbank_outstage #(.GRP_W(GRP_W)) u_out (
    .clk(clk), .rst(rst), .eff_sel(eff_sel), .sw_val(sw_res),
    .cfg0(cfg0), .cfg1(cfg1),
    .grp_q(grp_out), .solo_q(solo_out), .sw_rd_q(sw_rd)
  );
endmodule

// File: rtl/swbank_out_sel_chk.sv
module swbank_out_sel_chk #(
  parameter int GRP_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ovr_wr,
  input logic [2:0]       ovr_wdata,
  input swbank_pkg::hctl_t hctl_q,
  input logic [1:0]       eff_sel,
  input logic [GRP_W-1:0] sw_res,
  input logic [GRP_W:0]   cfg0,
  input logic [GRP_W:0]   cfg1,
  input logic [GRP_W-1:0] grp_out,
  input logic             solo_out,
  input logic [GRP_W-1:0] sw_rd
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (grp_out == '0 && !solo_out && sw_rd == '0 && !hctl_q.en));

  // R7
  hctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_wr |=> (hctl_q == $past(ovr_wdata)));

  // R4
  grp_sw_chk: assert property (@(posedge clk) disable iff (rst)
    eff_sel[0] |=> (grp_out == $past(sw_res)));

  // R2
  grp_cfg0_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_sel == 2'b10) |=> (grp_out == $past(cfg0[GRP_W-1:0]) && solo_out == $past(cfg0[GRP_W])));

  // R3
  grp_cfg1_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_sel == 2'b00) |=> (grp_out == $past(cfg1[GRP_W-1:0]) && solo_out == $past(cfg1[GRP_W])));

  // R5
  solo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    eff_sel[0] |=> (solo_out == $past(solo_out)));

  // R10
  sw_rd_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sw_rd == $past(sw_res)));
endmodule

bind swbank_out_sel swbank_out_sel_chk #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst(rst), .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
  .hctl_q(hctl_q), .eff_sel(eff_sel), .sw_res(sw_res),
  .cfg0(cfg0), .cfg1(cfg1), .grp_out(grp_out), .solo_out(solo_out), .sw_rd(sw_rd)
);

// File: tb/sim_swbank_out_sel.sv
module sim_swbank_out_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_pin = 2'b11;
  logic [1:0] sel_drv = 2'b11;
  logic [4:0] sw_in = '0;
  logic [4:0] sw_drv = 5'b11111;
  logic [5:0] cfg0 = '0;
  logic [5:0] cfg1 = '0;
  logic       ovr_wr = 1'b0;
  logic [2:0] ovr_wdata = '0;
  logic [4:0] grp_out;
  logic       solo_out;
  logic [4:0] sw_rd;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  swbank_out_sel u0 (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .sel_drv(sel_drv),
    .sw_in(sw_in), .sw_drv(sw_drv), .cfg0(cfg0), .cfg1(cfg1),
    .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
    .grp_out(grp_out), .solo_out(solo_out), .sw_rd(sw_rd)
  );

  typedef struct packed {
    logic       s1;
    logic       s0;
    logic [4:0] sw;
    logic [5:0] c0;
    logic [5:0] c1;
    logic [4:0] eg;
    logic       es;
  } vec_t;

  // solo expectations depend on the entry before (latch history)
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 5'b00000, 6'b110101, 6'b001010, 5'b10101, 1'b1},
    '{1'b0, 1'b0, 5'b00000, 6'b110101, 6'b001010, 5'b01010, 1'b0},
    '{1'b0, 1'b1, 5'b11001, 6'b110101, 6'b001010, 5'b11001, 1'b0},
    '{1'b1, 1'b1, 5'b00110, 6'b111111, 6'b101010, 5'b00110, 1'b0},
    '{1'b1, 1'b0, 5'b00110, 6'b100011, 6'b001010, 5'b00011, 1'b1},
    '{1'b1, 1'b1, 5'b10000, 6'b011111, 6'b001010, 5'b10000, 1'b1},
    '{1'b0, 1'b0, 5'b10000, 6'b011111, 6'b111100, 5'b11100, 1'b1},
    '{1'b0, 1'b1, 5'b01111, 6'b011111, 6'b000000, 5'b01111, 1'b1},
    '{1'b1, 1'b0, 5'b01111, 6'b001110, 6'b000000, 5'b01110, 1'b0},
    '{1'b0, 1'b0, 5'b01111, 6'b111111, 6'b000001, 5'b00001, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] w);
    ovr_wdata = w;
    ovr_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ovr_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    cfg0 = 6'b111111;
    step(); step();
    // R1: reset state
    chk("R1", "grp_out", grp_out, 5'b0);
    chk("R1", "solo_out", {4'b0, solo_out}, 5'b0);
    chk("R1", "sw_rd", sw_rd, 5'b0);
    rst = 1'b0;

    // table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < 10; i++) begin
      sel_pin = {VECS[i].s1, VECS[i].s0};
      sw_in = VECS[i].sw;
      cfg0 = VECS[i].c0;
      cfg1 = VECS[i].c1;
      step();
      chk(VECS[i].s0 ? "R4" : (VECS[i].s1 ? "R2" : "R3"), "grp_out", grp_out, VECS[i].eg);
      chk(VECS[i].s0 ? "R5/R6" : (VECS[i].s1 ? "R2" : "R3"), "solo_out", {4'b0, solo_out}, {4'b0, VECS[i].es});
    end

    // R10: readback
    sel_pin = 2'b11; sw_in = 5'b10110;
    step();
    chk("R10", "sw_rd", sw_rd, 5'b10110);
    chk("R4", "grp_out", grp_out, 5'b10110);

    // R9: undriven lines read 1
    sw_drv = 5'b00011; sw_in = 5'b00000; sel_drv = 2'b00; sel_pin = 2'b00;
    step();
    chk("R9", "sw_rd", sw_rd, 5'b11100);
    chk("R9", "grp_out", grp_out, 5'b11100);
    sw_drv = 5'b11111; sel_drv = 2'b11; sel_pin = 2'b11;

    // R7: host override
    cfg0 = 6'b100101; cfg1 = 6'b011000; sw_in = 5'b01001;
    host_write(3'b100);
    step();
    chk("R7", "grp_out", grp_out, 5'b11000);
    chk("R7", "solo_out", {4'b0, solo_out}, 5'b0);
    sel_pin = 2'b01;
    step();
    chk("R7", "grp_out pins ignored", grp_out, 5'b11000);
    host_write(3'b111);
    step();
    chk("R7", "grp_out", grp_out, 5'b01001);
    chk("R6", "solo_out", {4'b0, solo_out}, 5'b0);
    host_write(3'b110);
    step();
    chk("R7", "grp_out", grp_out, 5'b00101);
    chk("R7", "solo_out", {4'b0, solo_out}, 5'b1);

    // R8: disable returns control to pins
    host_write(3'b011);
    step();
    chk("R8", "grp_out", grp_out, 5'b01001);
    chk("R5", "solo_out", {4'b0, solo_out}, 5'b1);
    host_write(3'b100);
    step();
    chk("R7", "grp_out", grp_out, 5'b11000);
    sel_pin = 2'b10;
    rst = 1'b1;
    step();
    chk("R1", "grp_out", grp_out, 5'b0);
    chk("R1", "solo_out", {4'b0, solo_out}, 5'b0);
    rst = 1'b0;
    step();
    chk("R8", "grp_out after reset", grp_out, 5'b00101);
    chk("R8", "solo_out after reset", {4'b0, solo_out}, 5'b1);

    // R11: word 1 zero, select1 low
    cfg1 = 6'b000000; sel_pin = 2'b00;
    step();
    chk("R11", "grp_out", grp_out, 5'b0);
    chk("R11", "solo_out", {4'b0, solo_out}, 5'b0);
    sel_pin = 2'b01; sw_in = 5'b10101;
    step();
    chk("R11", "grp_out", grp_out, 5'b10101);
    chk("R11", "solo_out", {4'b0, solo_out}, 5'b0);

    finish_run();
  end
endmodule